// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block watches a wide set of already-synchronized general-purpose inputs for edges and turns them into interrupt requests. Every pin has its own rising-edge and falling-edge enable, each changed only through a pair of write-one strobe registers, so software can touch one pin without a read-modify-write. An enabled edge latches into a per-pin status bit, grouped 32 pins to a register, and software clears those bits by writing ones.

Status bits are gathered into 16-pin banks. Each bank drives one level interrupt line, gated by its own bit in a bank-enable register. A handler reads the half of a status register that belongs to its bank, clears what it saw, and repeats until nothing is left. The line stays high as long as any enabled status bit in its bank is still set. Built with a non-zero direct-pin count, the block instead gives each of the lowest pins a line of its own and holds the bank lines that cover those pins low.

Top module: `gpio_edge_irq`

## Requirements
- R1: Each 32-pin set k has its registers at byte address 0x10 + 0x20*k: 0x00 sets rising enables for the bits written as 1, 0x04 clears them, 0x08 sets falling enables, and 0x0C clears them. Reading 0x00 or 0x04 returns the rising enables, and reading 0x08 or 0x0C returns the falling enables.
- R2: A 0-to-1 change of a pin whose rising enable is set latches that pin's status bit (set k status at offset 0x10, bit i for pin 32k+i) at the clock edge that samples the new level. A 1-to-0 change does not latch it unless the falling enable is set.
- R3: A 1-to-0 change of a pin whose falling enable is set latches its status bit. With both enables set, either change latches it.
- R4: A change on a pin with no matching enable latches nothing. Clearing an enable leaves an already latched status bit set.
- R5: Writing a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R6: If a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: Bank line 2k is the OR of bits 15:0 of set k's status, and bank line 2k+1 is the OR of bits 31:16. The line stays high while any of those bits remains set.
- R8: The bank-enable register at address 0x08 holds bit b for bank line b. It is readable, and a bank line is low whenever its bit is 0.
- R9: After reset, all enables, status bits and bank-enable bits are 0, and every interrupt output is low.
- R10: With DIRECT_PINS = N > 0, the direct line for pin i < N equals that pin's status bit gated by the bank-enable bit of bank i/16. Every bank line whose 16 pins include a pin below N is held low.
- R11: Enable and status bits for pin positions at or above NUM_PINS cannot be set, and they read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | NUM_PINS | Synchronized pin levels |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| irqBank | output | (NUM_PINS+15)/16 | Level interrupt per 16-pin bank |
| irqDirect | output | max(DIRECT_PINS,1) | Per-pin direct interrupt lines |

## Verification
The bench builds two copies side by side with NUM_PINS = 40, which gives two status registers and three banks. The last bank covers a partly filled 32-pin set, so the handling of pins past the top one comes within reach. One copy has no direct pins. The other has DIRECT_PINS = 20, so the direct limit falls inside bank 1. That makes the hold-low rule for an overlapped bank visible, while bank 2 keeps working as a normal bank. Both copies get the same bus and pin stimulus, so every pattern checks the banked behaviour and the direct behaviour at once.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int SET_SEL_W     = 3;
  localparam int PINS_PER_SET  = 32;
  localparam int PINS_PER_BANK = 16;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_RISE_SET,
    REG_RISE_CLR,
    REG_FALL_SET,
    REG_FALL_CLR,
    REG_STATUS,
    REG_BANK_EN
  } regKind_e;

  typedef struct packed {
    logic                 wrBankEn;
    logic                 wrRiseSet;
    logic                 wrRiseClr;
    logic                 wrFallSet;
    logic                 wrFallClr;
    logic                 wrStatClr;
    logic [SET_SEL_W-1:0] setSel;
    logic [31:0]          data;
  } strobe_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_SETS  = 5,
  parameter int NUM_BANKS = 10
) (
  input  logic                     busWrEn,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [31:0]              busWrData,
  input  logic [NUM_SETS*32-1:0]   riseEn,
  input  logic [NUM_SETS*32-1:0]   fallEn,
  input  logic [NUM_SETS*32-1:0]   status,
  input  logic [NUM_BANKS-1:0]     bankEn,
  output strobe_t                  strb,
  output logic [31:0]              busRdData
);

  localparam logic [ADDR_W-1:0] BANK_EN_ADDR = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] SET_BASE     = ADDR_W'(8'h10);

  regKind_e             kind;
  logic [ADDR_W-1:0]    relAddr;
  logic [ADDR_W-1:0]    setIdx;
  logic [SET_SEL_W-1:0] setSel;
  int                   sliceBase;

  always_comb begin
    relAddr = busAddr - SET_BASE;
    setIdx  = relAddr >> 5;
    setSel  = SET_SEL_W'(setIdx);
    kind    = REG_NONE;
    if (busAddr == BANK_EN_ADDR) begin
      kind = REG_BANK_EN;
    end else if (busAddr >= SET_BASE && setIdx < ADDR_W'(NUM_SETS)) begin
      case (relAddr[4:0])
        5'h00:   kind = REG_RISE_SET;
        5'h04:   kind = REG_RISE_CLR;
        5'h08:   kind = REG_FALL_SET;
        5'h0C:   kind = REG_FALL_CLR;
        5'h10:   kind = REG_STATUS;
        default: kind = REG_NONE;
      endcase
    end
  end

  always_comb begin
    strb.wrBankEn  = busWrEn && (kind == REG_BANK_EN);
    strb.wrRiseSet = busWrEn && (kind == REG_RISE_SET);
    strb.wrRiseClr = busWrEn && (kind == REG_RISE_CLR);
    strb.wrFallSet = busWrEn && (kind == REG_FALL_SET);
    strb.wrFallClr = busWrEn && (kind == REG_FALL_CLR);
    strb.wrStatClr = busWrEn && (kind == REG_STATUS);
    strb.setSel    = setSel;
    strb.data      = busWrData;
  end

  always_comb begin
    sliceBase = int'(setSel) * PINS_PER_SET;
    busRdData = '0;
    case (kind)
      REG_RISE_SET, REG_RISE_CLR: busRdData = riseEn[sliceBase +: 32];
      REG_FALL_SET, REG_FALL_CLR: busRdData = fallEn[sliceBase +: 32];
      REG_STATUS:                 busRdData = status[sliceBase +: 32];
      REG_BANK_EN:                busRdData = 32'(bankEn);
      default:                    busRdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_edge_datapath.sv
module gpio_edge_datapath
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 160,
  parameter int NUM_SETS    = 5,
  parameter int NUM_BANKS   = 10,
  parameter int DIRECT_PINS = 0,
  parameter int DIR_W       = 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PINS-1:0]     pinIn,
  input  strobe_t                 strb,
  output logic [NUM_SETS*32-1:0]  riseEn,
  output logic [NUM_SETS*32-1:0]  fallEn,
  output logic [NUM_SETS*32-1:0]  status,
  output logic [NUM_BANKS-1:0]    bankEn,
  output logic [NUM_BANKS-1:0]    irqBank,
  output logic [DIR_W-1:0]        irqDirect
);

  localparam int PAD_W = NUM_SETS * PINS_PER_SET;
  localparam logic [PAD_W-1:0] VALID = PAD_W'({NUM_PINS{1'b1}});

  logic [PAD_W-1:0]    pinPad;
  logic [PAD_W-1:0]    prevPin;
  logic [PAD_W-1:0]    riseNext;
  logic [PAD_W-1:0]    fallNext;
  logic [PAD_W-1:0]    clrMask;
  logic [PAD_W-1:0]    newEvt;
  logic [PAD_W-1:0]    statusNext;
  logic [NUM_SETS-1:0] hitVec;

  assign pinPad = PAD_W'(pinIn);

  always_comb begin
    for (int k = 0; k < NUM_SETS; k++) begin
      hitVec[k] = (strb.setSel == SET_SEL_W'(k));
    end
  end

  always_comb begin
    riseNext = riseEn;
    fallNext = fallEn;
    clrMask  = '0;
    for (int k = 0; k < NUM_SETS; k++) begin
      if (hitVec[k] && strb.wrRiseSet) riseNext[k*32 +: 32] = riseEn[k*32 +: 32] | strb.data;
      if (hitVec[k] && strb.wrRiseClr) riseNext[k*32 +: 32] = riseEn[k*32 +: 32] & ~strb.data;
      if (hitVec[k] && strb.wrFallSet) fallNext[k*32 +: 32] = fallEn[k*32 +: 32] | strb.data;
      if (hitVec[k] && strb.wrFallClr) fallNext[k*32 +: 32] = fallEn[k*32 +: 32] & ~strb.data;
      if (hitVec[k] && strb.wrStatClr) clrMask[k*32 +: 32]  = strb.data;
    end
    newEvt     = (pinPad & ~prevPin & riseEn) | (~pinPad & prevPin & fallEn);
    statusNext = ((status & ~clrMask) | newEvt) & VALID;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevPin <= '0;
      riseEn  <= '0;
      fallEn  <= '0;
      status  <= '0;
      bankEn  <= '0;
    end else begin
      prevPin <= pinPad;
      riseEn  <= riseNext & VALID;
      fallEn  <= fallNext & VALID;
      status  <= statusNext;
      if (strb.wrBankEn) bankEn <= strb.data[NUM_BANKS-1:0];
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam bit OVERLAP = (DIRECT_PINS > 0) && (b * PINS_PER_BANK < DIRECT_PINS);
    if (OVERLAP) begin : g_held
      assign irqBank[b] = 1'b0;
    end else begin : g_live
      assign irqBank[b] = (|status[b*PINS_PER_BANK +: PINS_PER_BANK]) & bankEn[b];
    end
  end

  if (DIRECT_PINS > 0) begin : g_direct
    for (genvar i = 0; i < DIRECT_PINS; i++) begin : g_pin
      assign irqDirect[i] = status[i] & bankEn[i / PINS_PER_BANK];
    end
  end else begin : g_no_direct
    assign irqDirect = '0;
  end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS    = 160,
  parameter int DIRECT_PINS = 0,
  parameter int ADDR_W      = 8,
  localparam int NUM_SETS   = (NUM_PINS + 31) / 32,
  localparam int NUM_BANKS  = (NUM_PINS + 15) / 16,
  localparam int DIR_W      = (DIRECT_PINS > 0) ? DIRECT_PINS : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic                  busWrEn,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  output logic [NUM_BANKS-1:0]  irqBank,
  output logic [DIR_W-1:0]      irqDirect
);

  strobe_t                strb;
  logic [NUM_SETS*32-1:0] riseEn;
  logic [NUM_SETS*32-1:0] fallEn;
  logic [NUM_SETS*32-1:0] status;
  logic [NUM_BANKS-1:0]   bankEn;

  gpio_edge_ctrl #(
    .ADDR_W   (ADDR_W),
    .NUM_SETS (NUM_SETS),
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .busWrEn  (busWrEn),
    .busAddr  (busAddr),
    .busWrData(busWrData),
    .riseEn   (riseEn),
    .fallEn   (fallEn),
    .status   (status),
    .bankEn   (bankEn),
    .strb     (strb),
    .busRdData(busRdData)
  );

  gpio_edge_datapath #(
    .NUM_PINS   (NUM_PINS),
    .NUM_SETS   (NUM_SETS),
    .NUM_BANKS  (NUM_BANKS),
    .DIRECT_PINS(DIRECT_PINS),
    .DIR_W      (DIR_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .pinIn    (pinIn),
    .strb     (strb),
    .riseEn   (riseEn),
    .fallEn   (fallEn),
    .status   (status),
    .bankEn   (bankEn),
    .irqBank  (irqBank),
    .irqDirect(irqDirect)
  );

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS    = 160,
  parameter int DIRECT_PINS = 0,
  parameter int ADDR_W      = 8,
  localparam int NUM_BANKS  = (NUM_PINS + 15) / 16,
  localparam int DIR_W      = (DIRECT_PINS > 0) ? DIRECT_PINS : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PINS-1:0]  pinIn,
  input logic                 busWrEn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [31:0]          busWrData,
  input logic [NUM_BANKS-1:0] irqBank,
  input logic [DIR_W-1:0]     irqDirect
);

  // R9: lines are quiet in the first cycle out of reset
  p_quiet_after_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqBank == '0 && irqDirect == '0));

  // R8: a zero bank-enable write silences every line
  p_bank_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_W'(8'h08) && busWrData[NUM_BANKS-1:0] == '0)
      |=> (irqBank == '0 && irqDirect == '0));

  // R7: without writes or pin changes the lines hold their level
  p_hold_level_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && $stable(pinIn)) |=> ($stable(irqBank) && $stable(irqDirect)));

  if (NUM_BANKS >= 2) begin : g_clr
    // R5: clearing all of set 0 with steady pins drops banks 0 and 1
    p_full_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == ADDR_W'(8'h20) && busWrData == 32'hFFFF_FFFF && $stable(pinIn))
        |=> (irqBank[1:0] == 2'b00));
  end

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_PINS   (NUM_PINS),
  .DIRECT_PINS(DIRECT_PINS),
  .ADDR_W     (ADDR_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .pinIn    (pinIn),
  .busWrEn  (busWrEn),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .irqBank  (irqBank),
  .irqDirect(irqDirect)
);

// File: tb/gpio_edge_irq_bench.sv
module gpio_edge_irq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 40;
  localparam int ND         = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic          busWrEn = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   rdA, rdB;
  logic [2:0]    irqBankA, irqBankB;
  logic [0:0]    irqDirA;
  logic [ND-1:0] irqDirB;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq #(.NUM_PINS(NP), .DIRECT_PINS(0), .ADDR_W(8)) u_gpio_edge_irq (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdA), .irqBank(irqBankA), .irqDirect(irqDirA));

  gpio_edge_irq #(.NUM_PINS(NP), .DIRECT_PINS(ND), .ADDR_W(8)) u_gpio_edge_irq_direct (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(rdB), .irqBank(irqBankB), .irqDirect(irqDirB));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = rdA;
  endtask

  task automatic setPin(input int idx, input logic v);
    @(negedge clk);
    pinIn[idx] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R9 bank lines", 32'(irqBankA), 0);
    chk("R9 direct copy bank lines", 32'(irqBankB), 0);
    chk("R9 direct lines", 32'(irqDirB), 0);
    rdReg(8'h10, d); chk("R9 rise enables", d, 0);
    rdReg(8'h18, d); chk("R9 fall enables", d, 0);
    rdReg(8'h20, d); chk("R9 status", d, 0);
    rdReg(8'h08, d); chk("R9 bank enable", d, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wrReg(8'h10, 32'hF0); rdReg(8'h10, d); chk("R1 rise set", d, 32'hF0);
    wrReg(8'h14, 32'h30); rdReg(8'h14, d); chk("R1 rise clear", d, 32'hC0);
    wrReg(8'h18, 32'h0F); rdReg(8'h1C, d); chk("R1 fall set", d, 32'h0F);
    wrReg(8'h1C, 32'h0F); rdReg(8'h18, d); chk("R1 fall clear", d, 32'h0);
    wrReg(8'h30, 32'hFFFF_FFFF); rdReg(8'h30, d); chk("R11 set1 rise pad", d, 32'hFF);
    wrReg(8'h34, 32'hFFFF_FFFF); rdReg(8'h30, d); chk("R11 set1 rise cleared", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wrReg(8'h08, 32'h7); rdReg(8'h08, d); chk("R8 bank enable read", d, 32'h7);
    setPin(6, 1'b1);
    rdReg(8'h20, d); chk("R2 rise latched", d, 32'h40);
    chk("R7 bank0 line", 32'(irqBankA), 32'h1);
    chk("R10 direct line pin6", 32'(irqDirB), 32'h40);
    chk("R10 overlapped bank held", 32'(irqBankB), 32'h0);
    setPin(6, 1'b0);
    rdReg(8'h20, d); chk("R2 fall ignored", d, 32'h40);
    wrReg(8'h20, 32'h40);
    rdReg(8'h20, d); chk("R5 clear status", d, 32'h0);
    chk("R5 line drops", 32'(irqBankA), 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wrReg(8'h18, 32'h0010_0000);
    setPin(20, 1'b1);
    rdReg(8'h20, d); chk("R3 rise without enable", d, 32'h0);
    setPin(20, 1'b0);
    rdReg(8'h20, d); chk("R3 fall latched", d, 32'h0010_0000);
    chk("R7 bank1 from upper half", 32'(irqBankA), 32'h2);
    chk("R10 bank1 held in direct copy", 32'(irqBankB), 32'h0);
    wrReg(8'h20, 32'h0010_0000);
    wrReg(8'h10, 32'h0010_0000);
    setPin(20, 1'b1);
    rdReg(8'h20, d); chk("R3 both enables rise", d, 32'h0010_0000);
    wrReg(8'h20, 32'h0010_0000);
    setPin(20, 1'b0);
    rdReg(8'h20, d); chk("R3 both enables fall", d, 32'h0010_0000);
    wrReg(8'h20, 32'h0010_0000);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    setPin(3, 1'b1); setPin(3, 1'b0);
    rdReg(8'h20, d); chk("R4 unenabled pin", d, 32'h0);
    setPin(7, 1'b1);
    wrReg(8'h14, 32'h80);
    rdReg(8'h10, d); chk("R4 enable removed", d, 32'h0010_0040);
    rdReg(8'h20, d); chk("R4 latched bit kept", d, 32'h80);
    wrReg(8'h20, 32'h80);
    setPin(7, 1'b0); setPin(7, 1'b1);
    rdReg(8'h20, d); chk("R4 disabled edge", d, 32'h0);
    setPin(7, 1'b0);
  endtask

  task automatic t_partial();
    logic [31:0] d;
    wrReg(8'h10, 32'h6);
    @(negedge clk); pinIn[2:1] = 2'b11; @(negedge clk);
    rdReg(8'h20, d); chk("R2 two pins", d, 32'h6);
    wrReg(8'h20, 32'h2);
    rdReg(8'h20, d); chk("R5 partial clear", d, 32'h4);
    chk("R7 line held with bit left", 32'(irqBankA), 32'h1);
    wrReg(8'h20, 32'h0);
    rdReg(8'h20, d); chk("R5 zero write", d, 32'h4);
    wrReg(8'h20, 32'h4);
    chk("R7 line released", 32'(irqBankA), 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    setPin(1, 1'b0);
    rdReg(8'h20, d); chk("R6 setup no latch", d, 32'h0);
    @(negedge clk);
    pinIn[1] = 1'b1; busWrEn = 1'b1; busAddr = 8'h20; busWrData = 32'h2;
    @(negedge clk);
    busWrEn = 1'b0;
    rdReg(8'h20, d); chk("R6 edge beats clear", d, 32'h2);
    wrReg(8'h20, 32'h2);
  endtask

  task automatic t_bank();
    logic [31:0] d;
    wrReg(8'h30, 32'h80);
    setPin(39, 1'b1);
    rdReg(8'h40, d); chk("R7 set1 status", d, 32'h80);
    chk("R7 bank2 line", 32'(irqBankA), 32'h4);
    chk("R10 bank2 live in direct copy", 32'(irqBankB), 32'h4);
    wrReg(8'h08, 32'h3);
    chk("R8 bank2 disabled", 32'(irqBankA), 32'h0);
    rdReg(8'h40, d); chk("R8 status untouched", d, 32'h80);
    wrReg(8'h08, 32'h0);
    chk("R8 all off", 32'(irqBankA), 32'h0);
    wrReg(8'h08, 32'h7);
    chk("R8 re-enabled", 32'(irqBankA), 32'h4);
    wrReg(8'h40, 32'h80);
    chk("R5 set1 clear", 32'(irqBankA), 32'h0);
  endtask

  task automatic t_direct();
    wrReg(8'h10, 32'h0002_0000);
    setPin(17, 1'b1);
    chk("R10 direct pin17", 32'(irqDirB), 32'h0002_0000);
    chk("R10 bank line held", 32'(irqBankB), 32'h0);
    chk("R7 banked copy bank1", 32'(irqBankA), 32'h2);
    wrReg(8'h08, 32'h1);
    chk("R10 direct gated by bank1 enable", 32'(irqDirB), 32'h0);
    wrReg(8'h08, 32'h7);
    chk("R10 direct restored", 32'(irqDirB), 32'h0002_0000);
    wrReg(8'h20, 32'h0002_0000);
    chk("R10 direct cleared", 32'(irqDirB), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_rise();
    t_fall();
    t_sticky();
    t_partial();
    t_race();
    t_bank();
    t_direct();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule